// File: doc/BRIEF.md
# Conditional Relative Branch Sequencer

This block executes two short conditional branches, each testing one status flag, and advances the program counter past every other 16-bit instruction word. Each instruction cycle has four phase ticks, one per clock. The block accepts a word in the first tick of a cycle, together with the carry and negative flags and the word's own address. In the tick after the fourth phase it presents the next program counter, a taken indication and a one-tick done strobe.

The branch offset is an 8-bit two's complement count of halfwords. It is added to the address of the following word. A taken branch costs a second instruction cycle that does nothing. During that cycle the block raises busy so that the fetch logic holds off, and it ignores any word offered to it. The block has no flag outputs, so executing a branch cannot change the status flags.

Top module: `cbr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `next_pc` to 0, returns `phase` to 0, and drives `taken`, `done` and `busy` low on the following cycle.
- R2: `phase` steps 0,1,2,3 and then back to 0 on every clock. A word is accepted only when `instr_valid` is high in phase 0. Its result appears, with `done` high for exactly one clock, in the phase 0 tick that follows its phase 3.
- R3: A word whose upper byte is 8'hE3 branches when `flag_c` is 0. The new counter is then address + 2 + 2·n, where n is the signed lower byte, and `taken` is 1.
- R4: A word whose upper byte is 8'hE7 branches when `flag_n` is 0, using the same target rule as R3. Its outcome depends on `flag_n` only and never on `flag_c`.
- R5: A branch whose tested flag is 1 is not taken. `next_pc` becomes address + 2 and `taken` is 0.
- R6: Every other word advances `next_pc` to address + 2 with `taken` 0, whatever the values of both flags.
- R7: The offset spans -128 to +127 halfwords. At both extremes the target is exactly address + 2 - 256 and address + 2 + 254.
- R8: After a taken branch, `busy` is high for exactly the four ticks of the next instruction cycle. A word offered during that cycle is ignored and produces no `done`. A branch that is not taken leaves `busy` low.
- R9: Address bit 0 of `instr_pc` is ignored and `next_pc[0]` is always 0. All sums wrap modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per phase tick |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word offered this tick |
| instr_word | input | 16 | Instruction word |
| flag_c | input | 1 | Current carry flag |
| flag_n | input | 1 | Current negative flag |
| instr_pc | input | PC_W | Address of the offered word |
| next_pc | output | PC_W | Program counter after the last completed instruction |
| taken | output | 1 | Last completed instruction branched |
| done | output | 1 | One-tick strobe: a result was written |
| busy | output | 1 | Inserted idle cycle in progress |
| phase | output | 2 | Current phase tick (0 decode .. 3 write) |

## Verification
The bench builds the block with the default 21-bit counter. At that width the top-of-space address 0x1FFFFE and the address 0x000000 are both easy to reach. A sequential advance from the top wraps to zero, and a backward branch at the bottom wraps to the top. Both offset extremes are driven at ordinary addresses. A word is also pushed into the idle cycle, to show that it is dropped.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int unsigned IW = 16;

    localparam logic [7:0] OPC_BR_NO_CARRY = 8'hE3;
    localparam logic [7:0] OPC_BR_NO_NEG   = 8'hE7;

    typedef enum logic [1:0] {
        PH_DECODE  = 2'd0,
        PH_LITERAL = 2'd1,
        PH_PROCESS = 2'd2,
        PH_WRITE   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        K_SEQ   = 2'd0,
        K_IF_NC = 2'd1,
        K_IF_NN = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] ofs;
    } dec_t;

    function automatic dec_t classify(input logic [IW-1:0] w);
        dec_t d;
        d.ofs = w[7:0];
        unique case (w[15:8])
            OPC_BR_NO_CARRY: d.kind = K_IF_NC;
            OPC_BR_NO_NEG:   d.kind = K_IF_NN;
            default:         d.kind = K_SEQ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cbr_phase.sv
module cbr_phase
    import cbr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e ph
);
    always_ff @(posedge clk) begin
        if (rst) ph <= PH_DECODE;
        else     ph <= phase_e'(ph + 2'd1);
    end
endmodule

// File: rtl/cbr_target.sv
module cbr_target
    import cbr_pkg::*;
#(
    parameter int unsigned PC_W = 21
) (
    input  dec_t            dec,
    input  logic            fc,
    input  logic            fn,
    input  logic [PC_W-1:0] pc,
    output logic            go,
    output logic [PC_W-1:0] dest
);
    localparam int unsigned EXT = PC_W - 9;

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp;

    always_comb begin
        seq_pc = {pc[PC_W-1:1], 1'b0} + PC_W'(2);
        disp   = {{EXT{dec.ofs[7]}}, dec.ofs, 1'b0};
        unique case (dec.kind)
            K_IF_NC: go = ~fc;
            K_IF_NN: go = ~fn;
            default: go = 1'b0;
        endcase
        dest = go ? (seq_pc + disp) : seq_pc;
    end
endmodule

// File: rtl/cbr_seq.sv
module cbr_seq
    import cbr_pkg::*;
#(
    parameter int unsigned PC_W = 21
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [15:0]     instr_word,
    input  logic            flag_c,
    input  logic            flag_n,
    input  logic [PC_W-1:0] instr_pc,
    output logic [PC_W-1:0] next_pc,
    output logic            taken,
    output logic            done,
    output logic            busy,
    output logic [1:0]      phase
);
    phase_e          ph;
    logic            active;
    logic            idle;
    dec_t            cap_dec;
    logic            cap_c;
    logic            cap_n;
    logic [PC_W-1:0] cap_pc;
    logic            calc_go;
    logic [PC_W-1:0] calc_dest;
    logic            res_go;
    logic [PC_W-1:0] res_dest;

    cbr_phase u_phase (
        .clk (clk),
        .rst (rst),
        .ph  (ph)
    );

    cbr_target #(.PC_W(PC_W)) u_target (
        .dec  (cap_dec),
        .fc   (cap_c),
        .fn   (cap_n),
        .pc   (cap_pc),
        .go   (calc_go),
        .dest (calc_dest)
    );

    // decode phase: capture the word and its context
    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cap_dec <= '0;
            cap_c   <= 1'b0;
            cap_n   <= 1'b0;
            cap_pc  <= '0;
        end else if (ph == PH_DECODE) begin
            active <= instr_valid && !idle;
            if (instr_valid && !idle) begin
                cap_dec <= classify(instr_word);
                cap_c   <= flag_c;
                cap_n   <= flag_n;
                cap_pc  <= {instr_pc[PC_W-1:1], 1'b0};
            end
        end else if (ph == PH_WRITE) begin
            active <= 1'b0;
        end
    end

    // process phase: hold the computed outcome
    always_ff @(posedge clk) begin
        if (rst) begin
            res_go   <= 1'b0;
            res_dest <= '0;
        end else if (ph == PH_PROCESS) begin
            res_go   <= calc_go;
            res_dest <= calc_dest;
        end
    end

    // write phase: commit the counter and schedule the idle cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc <= '0;
            taken   <= 1'b0;
            done    <= 1'b0;
            idle    <= 1'b0;
        end else begin
            done <= (ph == PH_WRITE) && active;
            if (ph == PH_WRITE) begin
                if (active) begin
                    next_pc <= res_dest;
                    taken   <= res_go;
                    idle    <= res_go;
                end else begin
                    idle <= 1'b0;
                end
            end
        end
    end

    assign busy  = idle;
    assign phase = ph;

endmodule

// File: rtl/cbr_seq_chk.sv
module cbr_seq_chk #(
    parameter int unsigned PC_W = 21
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] next_pc,
    input logic            taken,
    input logic            done,
    input logic            busy,
    input logic [1:0]      phase
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (next_pc == '0 && phase == 2'd0 && !done && !busy && !taken)); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst) phase != 2'd3 |=> phase == $past(phase) + 2'd1); // R2
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst) phase == 2'd3 |=> phase == 2'd0); // R2
    AST_DONE_AT_START: assert property (@(posedge clk) disable iff (rst) done |-> phase == 2'd0); // R2
    AST_TAKEN_STALLS: assert property (@(posedge clk) disable iff (rst) (done && taken) |-> busy); // R8
    AST_FALLTHRU_NO_STALL: assert property (@(posedge clk) disable iff (rst) (done && !taken) |-> !busy); // R8
    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst) (busy && phase == 2'd3) |=> (!done && !busy)); // R8
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst) (busy && phase != 2'd3) |=> busy); // R8
    AST_PC_EVEN: assert property (@(posedge clk) disable iff (rst) !next_pc[0]); // R9
endmodule

bind cbr_seq cbr_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .next_pc (next_pc),
    .taken   (taken),
    .done    (done),
    .busy    (busy),
    .phase   (phase)
);

// File: tb/sim_cbr_seq.sv
`timescale 1ns/1ps
module sim_cbr_seq;
    localparam int unsigned PC_W = 21;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            instr_valid = 1'b0;
    logic [15:0]     instr_word = '0;
    logic            flag_c = 1'b0;
    logic            flag_n = 1'b0;
    logic [PC_W-1:0] instr_pc = '0;
    logic [PC_W-1:0] next_pc;
    logic            taken;
    logic            done;
    logic            busy;
    logic [1:0]      phase;

    int checks = 0;
    int fails  = 0;
    int busy_left = 0;

    logic [PC_W-1:0] q_pc[$];
    logic            q_tk[$];
    string           q_req[$];

    always #4 clk = ~clk;

    cbr_seq #(.PC_W(PC_W)) u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .flag_c(flag_c), .flag_n(flag_n), .instr_pc(instr_pc),
        .next_pc(next_pc), .taken(taken), .done(done), .busy(busy), .phase(phase)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected outcome, from the requirement text
    task automatic issue(input logic [15:0] w, input logic c, input logic n,
                         input logic [PC_W-1:0] pc, input string req);
        logic [PC_W-1:0] base;
        logic [PC_W-1:0] step;
        logic            br;
        base = {pc[PC_W-1:1], 1'b0} + PC_W'(2);
        br   = (w[15:8] == 8'hE3 && !c) || (w[15:8] == 8'hE7 && !n);
        step = PC_W'(signed'({{(PC_W-8){w[7]}}, w[7:0]}) * 2);
        do @(negedge clk); while (!(phase == 2'd0 && !busy));
        instr_valid = 1'b1; instr_word = w; flag_c = c; flag_n = n; instr_pc = pc;
        q_pc.push_back(br ? base + step : base);
        q_tk.push_back(br);
        q_req.push_back(req);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    // offer a word while the idle cycle runs; it must be dropped (R8)
    task automatic poke_idle();
        do @(negedge clk); while (!(phase == 2'd0 && busy));
        instr_valid = 1'b1; instr_word = 16'hE300; flag_c = 1'b0; flag_n = 1'b0;
        instr_pc = PC_W'(24'h000400);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (q_pc.size() == 0) begin
                    check("R8 unexpected done", 32'd1, 32'd0);
                end else begin
                    string r;
                    logic [PC_W-1:0] ep;
                    logic et;
                    ep = q_pc.pop_front(); et = q_tk.pop_front(); r = q_req.pop_front();
                    check({r, " next_pc"}, 32'(next_pc), 32'(ep));
                    check({r, " taken"}, 32'(taken), 32'(et));
                    check("R2 done phase", 32'(phase), 32'd0);
                end
                if (taken) begin
                    check("R8 busy on taken", 32'(busy), 32'd1);
                    busy_left = 3;
                end else begin
                    check("R8 no busy on fallthrough", 32'(busy), 32'd0);
                    busy_left = 0;
                end
            end else if (busy_left > 0) begin
                check("R8 busy held", 32'(busy), 32'd1);
                busy_left--;
            end else begin
                check("R8 busy low", 32'(busy), 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 next_pc", 32'(next_pc), 32'd0);
        check("R1 taken", 32'(taken), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 phase", 32'(phase), 32'd1);

        issue(16'hE305, 1'b0, 1'b1, 21'h000100, "R3 carry clear +5");
        issue(16'hE305, 1'b1, 1'b0, 21'h000100, "R5 carry set");
        issue(16'hE7FF, 1'b1, 1'b0, 21'h000200, "R4 neg clear -1");
        issue(16'hE710, 1'b0, 1'b1, 21'h000200, "R4 neg set ignores carry");
        issue(16'hE380, 1'b0, 1'b0, 21'h000300, "R7 offset -128");
        issue(16'hE37F, 1'b0, 1'b0, 21'h000300, "R7 offset +127");
        issue(16'h1234, 1'b0, 1'b0, 21'h000500, "R6 other word flags low");
        issue(16'hE400, 1'b1, 1'b1, 21'h000502, "R6 other word flags high");
        issue(16'h0000, 1'b0, 1'b0, 21'h1FFFFE, "R9 sequential wrap");
        issue(16'hE380, 1'b0, 1'b0, 21'h000000, "R9 backward wrap");
        issue(16'hE702, 1'b0, 1'b0, 21'h000101, "R9 odd address");
        issue(16'hE310, 1'b0, 1'b0, 21'h000600, "R8 taken then poke");
        poke_idle();
        issue(16'h4000, 1'b0, 1'b0, 21'h000700, "R2 after idle");

        repeat (12) @(negedge clk);
        check("R8 leftover results", 32'(q_pc.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule